// File: doc/BRIEF.md
# Cascaded First-Word-Fall-Through FIFO Chain

This block joins a configurable number of first-word-fall-through FIFO stages into one deeper queue on a single clock. Each stage has the same write and read interface. The chain wires them so that a stage's active-low "word available" flag drives the next stage's write enable, and the next stage's active-low "room available" flag drives the read enable of the stage before it. No logic sits between stages. The total depth is the sum of the stage depths.

Each stage has fixed flag latencies. A word written into a stage shows at that stage's output three clocks after the write edge. Space freed by a read reaches that stage's room flag two clocks after the read edge. Words therefore ripple toward the output end without any read command, and free slots bubble back toward the input end. A word that enters an empty chain pays one hop latency per stage. Once the last stage holds data, the queue streams one word per clock with no further chain delay.

The user drives a write port and a read port, both active-low. Write data is taken on the clock edge where `put_n` and `room_n` are both low. The head word stays on `take_data` while `avail_n` is low, and it is consumed on the edge where `take_n` is also low.

Top module: `fwft_cascade`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `room_n` reads 0 (space free) and `avail_n` reads 1 (nothing to read).
- R2: Words leave at `take_data` in exactly the order they were accepted. None is lost and none is repeated.
- R3: A single word written into an empty chain makes `avail_n` fall exactly (N_STAGES-1)*4+3 clock edges after its write edge, and the word is then on `take_data`. With the defaults this is 7 edges.
- R4: Once the last stage shows a word and further words sit deeper in the chain, back-to-back reads on every clock find `avail_n` low on each cycle, with no gaps.
- R5: The chain accepts exactly N_STAGES*STAGE_DEPTH words with no reads. After that `room_n` stays high.
- R6: After one read from a completely full, settled chain, `room_n` falls exactly (N_STAGES-1)*3+2 clock edges after the read edge. With the defaults this is 5 edges.
- R7: A write offered while `room_n` is high is ignored: the word is never stored and never appears at the output.
- R8: A read offered while `avail_n` is high is ignored. It does not change the latency or the content of the next word written.
- R9: While `avail_n` is low and `take_n` is high, `avail_n` stays low and `take_data` keeps its value. `avail_n` rises only after a read edge.
- R10: On a chain that is neither empty nor full, a write and a read in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, also the inter-stage transfer clock |
| rst | input | 1 | Synchronous active-high reset; empties every stage |
| put_n | input | 1 | Active-low write request |
| put_data | input | DATA_W | Write data |
| room_n | output | 1 | Active-low: the first stage can take a word |
| take_n | input | 1 | Active-low read request |
| take_data | output | DATA_W | Head word of the chain (last stage output) |
| avail_n | output | 1 | Active-low: a valid word is on take_data |

## Verification
The interesting overlap is a write into the first stage and a read from the last stage on the same edge. Two cases are tested. In the first, the bench keeps `put_n` and `take_n` both low for twenty cycles on a half-filled chain. The scoreboard then has to see every new word emerge in order while `avail_n` never rises. In the second, a write is offered in the very cycle that the first read is taken from a full chain. That write must be refused, because `room_n` only falls five edges later. If the refused word ever reached the output, the scoreboard order check would catch it.

// File: rtl/cascade_pkg.sv
`timescale 1ns/1ps
package cascade_pkg;
  // Edges from a stage's write edge to its own output flag falling.
  localparam int unsigned SHOW_LAT = 3;
  // Edges from a stage's read edge to its own room flag falling.
  localparam int unsigned FREE_LAT = 2;
  // One extra edge per hop: the neighbour samples the flag first.
  localparam int unsigned HOP_SHOW = SHOW_LAT + 1;
  localparam int unsigned HOP_FREE = FREE_LAT + 1;

  function automatic int unsigned chain_show_lat(input int unsigned n);
    return (n - 1) * HOP_SHOW + SHOW_LAT;
  endfunction

  function automatic int unsigned chain_free_lat(input int unsigned n);
    return (n - 1) * HOP_FREE + FREE_LAT;
  endfunction
endpackage

// File: rtl/cascade_ram.sv
`timescale 1ns/1ps
module cascade_ram #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port: doubles as the stage output register.
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/cascade_pulse_dly.sv
`timescale 1ns/1ps
module cascade_pulse_dly #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_in,
  output logic pulse_out
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= pulse_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], pulse_in};
      end
    end
  endgenerate

  assign pulse_out = sr[STAGES-1];
endmodule

// File: rtl/cascade_stage.sv
`timescale 1ns/1ps
module cascade_stage
  import cascade_pkg::*;
#(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              put_n,
  input  logic [DATA_W-1:0] put_data,
  output logic              room_n,
  input  logic              take_n,
  output logic [DATA_W-1:0] take_data,
  output logic              avail_n
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic          wr_ok, rd_ok;
  logic          wr_late, rd_late;
  logic          fetch;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] held, held_nxt;
  logic [CW-1:0] shown_cnt, shown_sum;

  assign wr_ok = !put_n && !room_n;
  assign rd_ok = !avail_n && !take_n;

  // A write becomes visible to the read side only after SHOW_LAT edges.
  cascade_pulse_dly #(.STAGES(SHOW_LAT)) u_wr_dly (
    .clk(clk), .rst(rst), .pulse_in(wr_ok), .pulse_out(wr_late)
  );

  // A read returns its slot to the write side after FREE_LAT edges.
  cascade_pulse_dly #(.STAGES(FREE_LAT)) u_rd_dly (
    .clk(clk), .rst(rst), .pulse_in(rd_ok), .pulse_out(rd_late)
  );

  // Write side: occupancy seen by the room flag (never below true count).
  assign held_nxt = held + CW'(wr_ok) - CW'(rd_late);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      held   <= '0;
      room_n <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr <= wr_ptr + AW'(1);
      held   <= held_nxt;
      room_n <= (held_nxt == CW'(DEPTH));
    end
  end

  // Read side: words in RAM that are visible but not yet on the output.
  assign shown_sum = shown_cnt + CW'(wr_late);
  assign fetch     = (avail_n || rd_ok) && (shown_sum != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr    <= '0;
      shown_cnt <= '0;
      avail_n   <= 1'b1;
    end else begin
      if (fetch) rd_ptr <= rd_ptr + AW'(1);
      shown_cnt <= shown_sum - CW'(fetch);
      if (fetch)      avail_n <= 1'b0;
      else if (rd_ok) avail_n <= 1'b1;
    end
  end

  cascade_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk  (clk),
    .we   (wr_ok),
    .waddr(wr_ptr),
    .wdata(put_data),
    .re   (fetch),
    .raddr(rd_ptr),
    .rdata(take_data)
  );
endmodule

// File: rtl/fwft_cascade.sv
`timescale 1ns/1ps
module fwft_cascade #(
  parameter int unsigned DATA_W      = 18,
  parameter int unsigned STAGE_DEPTH = 16,
  parameter int unsigned N_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              put_n,
  input  logic [DATA_W-1:0] put_data,
  output logic              room_n,
  input  logic              take_n,
  output logic [DATA_W-1:0] take_data,
  output logic              avail_n
);
  localparam int unsigned LAST = N_STAGES - 1;

  logic [N_STAGES-1:0] s_put_n, s_room_n, s_take_n, s_avail_n;
  logic [DATA_W-1:0]   s_din  [N_STAGES];
  logic [DATA_W-1:0]   s_dout [N_STAGES];

  generate
    for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_head
        assign s_put_n[g] = put_n;
        assign s_din[g]   = put_data;
      end else begin : g_link_in
        // Output-valid of the previous stage is this stage's write enable.
        assign s_put_n[g] = s_avail_n[g-1];
        assign s_din[g]   = s_dout[g-1];
      end

      if (g == LAST) begin : g_tail
        assign s_take_n[g] = take_n;
      end else begin : g_link_out
        // Room flag of the next stage is this stage's read enable.
        assign s_take_n[g] = s_room_n[g+1];
      end

      cascade_stage #(.DATA_W(DATA_W), .DEPTH(STAGE_DEPTH)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .put_n    (s_put_n[g]),
        .put_data (s_din[g]),
        .room_n   (s_room_n[g]),
        .take_n   (s_take_n[g]),
        .take_data(s_dout[g]),
        .avail_n  (s_avail_n[g])
      );
    end
  endgenerate

  assign room_n    = s_room_n[0];
  assign avail_n   = s_avail_n[LAST];
  assign take_data = s_dout[LAST];
endmodule

// File: rtl/cascade_chk.sv
`timescale 1ns/1ps
module cascade_chk #(
  parameter int unsigned DATA_W      = 18,
  parameter int unsigned STAGE_DEPTH = 16,
  parameter int unsigned N_STAGES    = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              put_n,
  input logic              room_n,
  input logic              take_n,
  input logic              avail_n,
  input logic [DATA_W-1:0] take_data
);
  localparam int unsigned CAP = STAGE_DEPTH * N_STAGES;
  localparam int unsigned OW  = $clog2(CAP + 1);

  logic [OW-1:0] occ;

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else     occ <= occ + OW'(!put_n && !room_n) - OW'(!take_n && !avail_n);
  end

  // R1
  reset_flags_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (avail_n && !room_n));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= OW'(CAP));

  // R5
  full_room_chk: assert property (@(posedge clk) disable iff (rst)
    (occ == OW'(CAP)) |-> room_n);

  // R2
  empty_avail_chk: assert property (@(posedge clk) disable iff (rst)
    (occ == '0) |-> avail_n);

  // R9
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!avail_n && take_n) |=> (!avail_n && $stable(take_data)));

  // R9
  avail_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(avail_n) |-> $past(!take_n));
endmodule

bind fwft_cascade cascade_chk #(
  .DATA_W(DATA_W), .STAGE_DEPTH(STAGE_DEPTH), .N_STAGES(N_STAGES)
) u_cascade_chk (
  .clk(clk), .rst(rst), .put_n(put_n), .room_n(room_n),
  .take_n(take_n), .avail_n(avail_n), .take_data(take_data)
);

// File: tb/test_fwft_cascade.sv
`timescale 1ns/1ps
module test_fwft_cascade;
  localparam int DATA_W      = 18;
  localparam int STAGE_DEPTH = 16;
  localparam int N_STAGES    = 2;
  localparam int CAP         = STAGE_DEPTH * N_STAGES;
  localparam int SHOW_EDGES  = (N_STAGES - 1) * 4 + 3;  // R3
  localparam int FREE_EDGES  = (N_STAGES - 1) * 3 + 2;  // R6

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              put_n = 1'b1;
  logic              take_n = 1'b1;
  logic [DATA_W-1:0] put_data = '0;
  logic              room_n, avail_n;
  logic [DATA_W-1:0] take_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int sb[$];

  always #2.5 clk = ~clk;

  fwft_cascade #(
    .DATA_W(DATA_W), .STAGE_DEPTH(STAGE_DEPTH), .N_STAGES(N_STAGES)
  ) i_fwft_cascade (
    .clk(clk), .rst(rst), .put_n(put_n), .put_data(put_data),
    .room_n(room_n), .take_n(take_n), .take_data(take_data), .avail_n(avail_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Driver: offer one write this cycle; record it if the chain takes it.
  task automatic offer(input int val);
    put_n    = 1'b0;
    put_data = DATA_W'(val);
    if (!room_n) sb.push_back(val);
  endtask

  // Monitor: a read occurs at the next edge; compare the head word now.
  always @(negedge clk) begin
    if (!rst && !take_n && !avail_n) begin
      if (sb.size() == 0) check(1'b0, "R2 unexpected word", int'(take_data), -1);
      else begin
        int exp_v;
        exp_v = sb.pop_front();
        check(int'(take_data) == exp_v, "R2 order", int'(take_data), exp_v);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int acc;
    repeat (4) tick();
    check(room_n == 1'b0, "R1 room during reset", room_n, 0);
    rst = 1'b0;
    tick();
    check(room_n == 1'b0, "R1 room after reset", room_n, 0);
    check(avail_n == 1'b1, "R1 avail after reset", avail_n, 1);

    // R3 / R9: single word through the empty chain.
    offer(18'h1234);
    tick();
    put_n = 1'b1;
    for (int k = 1; k <= SHOW_EDGES + 3; k++) begin
      tick();
      if (k < SHOW_EDGES)
        check(avail_n == 1'b1, "R3 early avail", avail_n, 1);
      else if (k == SHOW_EDGES) begin
        check(avail_n == 1'b0, "R3 first word latency", avail_n, 0);
        check(take_data == 18'h1234, "R3 first word data", int'(take_data), 'h1234);
      end else begin
        check(avail_n == 1'b0, "R9 flag held", avail_n, 0);
        check(take_data == 18'h1234, "R9 data held", int'(take_data), 'h1234);
      end
    end
    take_n = 1'b0;
    tick();
    take_n = 1'b1;
    tick();
    check(avail_n == 1'b1, "R9 empty after read", avail_n, 1);

    // R8: reads on an empty chain are ignored.
    take_n = 1'b0;
    repeat (5) tick();
    take_n = 1'b1;
    check(avail_n == 1'b1, "R8 still empty", avail_n, 1);
    offer(18'h0abc);
    tick();
    put_n = 1'b1;
    repeat (SHOW_EDGES - 1) tick();
    check(avail_n == 1'b1, "R8 latency unchanged (early)", avail_n, 1);
    tick();
    check(avail_n == 1'b0, "R8 latency unchanged", avail_n, 0);
    check(take_data == 18'h0abc, "R8 data", int'(take_data), 'h0abc);
    take_n = 1'b0;
    tick();
    take_n = 1'b1;
    repeat (3) tick();

    // R5: fill with no reads.
    acc = 0;
    for (int i = 0; i < CAP + 16; i++) begin
      if (!room_n) acc++;
      offer(100 + i);
      tick();
    end
    put_n = 1'b1;
    repeat (40) tick();
    check(acc == CAP, "R5 accepted count", acc, CAP);
    check(room_n == 1'b1, "R5 full flag", room_n, 1);

    // R7: writes while full are refused and must never emerge.
    for (int i = 0; i < 4; i++) begin
      offer(900 + i);
      tick();
    end
    put_n = 1'b1;
    check(room_n == 1'b1, "R7 still full", room_n, 1);

    // R6 / R10: one read from full, with a write offered the same cycle.
    take_n = 1'b0;
    offer(999);
    tick();
    take_n = 1'b1;
    put_n  = 1'b1;
    for (int k = 1; k <= FREE_EDGES; k++) begin
      tick();
      if (k < FREE_EDGES) check(room_n == 1'b1, "R6 early room", room_n, 1);
      else                check(room_n == 1'b0, "R6 room latency", room_n, 0);
    end
    repeat (10) tick();

    // R4: back-to-back drain without gaps.
    for (int i = 0; i < CAP - 1; i++) begin
      take_n = 1'b0;
      check(avail_n == 1'b0, "R4 no bubble", avail_n, 0);
      tick();
    end
    take_n = 1'b1;
    repeat (2) tick();
    check(avail_n == 1'b1, "R4 empty after drain", avail_n, 1);
    check(sb.size() == 0, "R2 nothing lost", sb.size(), 0);

    // R10: concurrent write and read on a half-filled chain.
    for (int i = 0; i < 10; i++) begin
      offer(300 + i);
      tick();
    end
    put_n = 1'b1;
    repeat (15) tick();
    for (int i = 0; i < 20; i++) begin
      offer(500 + i);
      take_n = 1'b0;
      check(avail_n == 1'b0, "R10 read side live", avail_n, 0);
      check(room_n == 1'b0, "R10 write side live", room_n, 0);
      tick();
    end
    put_n = 1'b1;
    repeat (60) tick();
    take_n = 1'b1;
    tick();
    check(sb.size() == 0, "R10 all words delivered", sb.size(), 0);
    check(avail_n == 1'b1, "R10 empty at end", avail_n, 1);

    finish_run();
  end
endmodule